// File: doc/BRIEF.md
# Intra-Row Permutation Sequence Generator

This block computes the column order used inside one row of a turbo-code interleaver matrix. Software or a sequencing block supplies a prime `p`, a column case (matrix width equal to `p`, `p+1` or `p-1`), a row number, the choice of row-reordering pattern and a flag that says the block length exactly fills the matrix. After one start pulse the generator finds the primitive root of `p`, stores the powers of that root in an internal RAM, picks the prime multiplier that belongs to the requested row, and then streams the column indices of that row, one per clock, with a valid strobe and a last marker.

The row multiplier is found without a general multiplier or divider. Candidate primes are tested against `p-1` by repeated subtraction, and the RAM is walked with a running index that steps by the multiplier and wraps by a conditional subtraction. The readout reordering of whole rows and the removal of padding positions are handled elsewhere.

Top module: `intra_row_perm_gen`

## Requirements
- R1: After reset, `busy`, `col_valid` and `col_last` are low.
- R2: The root `g` is the smallest integer of order `p-1` modulo `p` (for example 19 for `p`=191, 3 for `p`=257). The base sequence is `c(0)=1` and `c(i)=g*c(i-1) mod p` for `i` up to `p-2`.
- R3: The multiplier of row `r` is `q_k`, where `k` is the position holding `r` in the selected pattern. `q_0=1`, and `q_k` for `k>0` is the k-th prime above 6 that does not divide `p-1`.
- R4: With `col_case`=0 (width `p`), `p` indices are emitted. Position `i<p-1` carries `c((i*m) mod (p-1))`, where `m` is the row multiplier, and position `p-1` carries 0. No emitted index exceeds `p`.
- R5: With `col_case`=1 (width `p+1`), `p+1` indices are emitted. Positions below `p` follow R4, and position `p` carries `p`.
- R6: With `col_case`=1, `full_blk`=1 and the row equal to the last row (19 for patterns 0 and 1, 9 for pattern 2), the first index is `p` and the final index is 1. Otherwise no exchange takes place.
- R7: With `col_case`=2 (width `p-1`), `p-1` indices are emitted. Each one is `c((i*m) mod (p-1)) - 1`.
- R8: `pat_sel` selects the row-order pattern. Pattern 0 is {19,9,14,4,0,2,5,7,12,18,10,8,13,17,3,1,16,6,15,11}, pattern 1 is {19,9,14,4,0,2,5,7,12,18,16,13,17,15,3,1,6,11,8,10}, and pattern 2 is {9,8,7,6,5,4,3,2,1,0}.
- R9: `busy` rises only after an accepted `start` and stays high until the cycle carrying `col_last`. `col_valid` is asserted on consecutive cycles from the first index to the last, and `col_last` marks the final index. `busy` is low in the cycle after `col_last`.
- R10: Inputs are captured only at an accepted start (`start` while `busy` is low). A `start` pulse or input change while `busy` is high has no effect on the emitted row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one row; accepted only when idle |
| prime_p | input | 9 | Prime `p` (17 to 257) |
| col_case | input | 2 | 0: width `p`, 1: width `p+1`, 2: width `p-1` |
| row_idx | input | 5 | Row whose permutation is generated |
| pat_sel | input | 2 | Row-order pattern: 0, 1 or 2 |
| full_blk | input | 1 | Block length equals rows times columns |
| busy | output | 1 | Generation in progress |
| col_valid | output | 1 | `col_idx` carries an index |
| col_idx | output | 9 | Permuted column index |
| col_last | output | 1 | Final index of the row |

## Verification
An error in root search or in the base sequence corrupts almost every emitted index. The error is already visible in the second index of a row whose multiplier is 1. A wrong multiplier choice or pattern inverse shows from the second index of any other row. A wrong wrap of the running index first shows at the position where `i*m` passes `p-1`, which is within a few cycles for large multipliers. End corrections and the last-row exchange only appear in the first and final one or two indices. Each column case and both exchange conditions are therefore run with complete rows compared against an independent model. Handshake faults appear as gaps in `col_valid`, a missing `col_last`, or `busy` held high past the final index.

// File: rtl/intra_perm_pkg.sv
package intra_perm_pkg;

  localparam int PRIME_W  = 9;
  localparam int ROW_W    = 5;
  localparam int ORDER_N  = 20;
  localparam int NUM_CAND = 24;
  localparam int CAND_W   = 7;

  typedef enum logic [1:0] {
    CCASE_EQ    = 2'd0,
    CCASE_PLUS  = 2'd1,
    CCASE_MINUS = 2'd2,
    CCASE_RSVD  = 2'd3
  } ccase_e;

  typedef enum logic [1:0] {
    PSEL_A    = 2'd0,
    PSEL_B    = 2'd1,
    PSEL_C    = 2'd2,
    PSEL_RSVD = 2'd3
  } psel_e;

  // Row order tables: entry k is the source row placed at position k.
  localparam logic [4:0] ORDER_A [ORDER_N] = '{
    5'd19, 5'd9, 5'd14, 5'd4, 5'd0, 5'd2, 5'd5, 5'd7, 5'd12, 5'd18,
    5'd10, 5'd8, 5'd13, 5'd17, 5'd3, 5'd1, 5'd16, 5'd6, 5'd15, 5'd11};
  localparam logic [4:0] ORDER_B [ORDER_N] = '{
    5'd19, 5'd9, 5'd14, 5'd4, 5'd0, 5'd2, 5'd5, 5'd7, 5'd12, 5'd18,
    5'd16, 5'd13, 5'd17, 5'd15, 5'd3, 5'd1, 5'd6, 5'd11, 5'd8, 5'd10};
  // Ten-row pattern, padded with an unused code.
  localparam logic [4:0] ORDER_C [ORDER_N] = '{
    5'd9, 5'd8, 5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0,
    5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31};

  function automatic bit is_prime_c(int n);
    if (n < 2) return 1'b0;
    for (int d = 2; d * d <= n; d++) begin
      if (n % d == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  // idx-th prime that is at least 7 (elaboration-time only).
  function automatic int cand_prime(int idx);
    int cnt;
    cnt = -1;
    for (int n = 7; n < 512; n++) begin
      if (is_prime_c(n)) begin
        cnt++;
        if (cnt == idx) return n;
      end
    end
    return 7;
  endfunction

  function automatic logic [4:0] order_entry(logic [1:0] sel, int k);
    case (sel)
      PSEL_B:  return ORDER_B[k];
      PSEL_C:  return ORDER_C[k];
      default: return ORDER_A[k];
    endcase
  endfunction

  // Position k at which the given row sits in the selected pattern.
  function automatic logic [4:0] order_inverse(logic [1:0] sel, logic [4:0] row);
    logic [4:0] res;
    res = '0;
    for (int k = 0; k < ORDER_N; k++) begin
      if (order_entry(sel, k) == row) res = 5'(k);
    end
    return res;
  endfunction

  function automatic logic [4:0] last_row(logic [1:0] sel);
    return (sel == PSEL_C) ? 5'd9 : 5'd19;
  endfunction

endpackage

// File: rtl/intra_seq_ram.sv
module intra_seq_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/intra_base_seq.sv
module intra_base_seq #(
  parameter int PW = 9,
  parameter int AW = 8,
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [PW-1:0] prime,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_data,
  output logic          done
);
  localparam int PRODW = PW + GW;

  logic          run_q, run_d;
  logic [GW-1:0] g_q, g_d;
  logic [PW-1:0] cur_q, cur_d;
  logic [AW-1:0] i_q, i_d;
  logic          done_q, done_d;
  logic [PRODW-1:0] red;
  logic [PW-1:0] nxt;
  logic          back_to_one, at_end;

  // g*cur mod p: the product is below 2^GW * p, so GW restoring steps suffice.
  always_comb begin
    red = PRODW'(g_q) * PRODW'(cur_q);
    for (int s = GW - 1; s >= 0; s--) begin
      if (red >= (PRODW'(prime) << s)) red = red - (PRODW'(prime) << s);
    end
    nxt = red[PW-1:0];
  end

  assign back_to_one = (i_q != '0) && (cur_q == PW'(1));
  assign at_end      = (PW'(i_q) == prime - PW'(2));

  always_comb begin
    run_d  = run_q;
    g_d    = g_q;
    cur_d  = cur_q;
    i_d    = i_q;
    done_d = done_q;
    if (kick) begin
      run_d  = 1'b1;
      g_d    = GW'(2);
      cur_d  = PW'(1);
      i_d    = '0;
      done_d = 1'b0;
    end else if (run_q) begin
      if (back_to_one) begin
        // Order of g is below p-1: try the next root candidate.
        g_d   = g_q + GW'(1);
        cur_d = PW'(1);
        i_d   = '0;
      end else if (at_end) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cur_d = nxt;
        i_d   = i_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      g_q    <= '0;
      cur_q  <= '0;
      i_q    <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      g_q    <= g_d;
      cur_q  <= cur_d;
      i_q    <= i_d;
      done_q <= done_d;
    end
  end

  assign wr_en   = run_q;
  assign wr_addr = i_q;
  assign wr_data = cur_q;
  assign done    = done_q;
endmodule

// File: rtl/intra_mult_sel.sv
module intra_mult_sel
  import intra_perm_pkg::*;
#(
  parameter int PW = 9,
  parameter int RW = 5,
  parameter int NC = 24,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [PW-1:0] prime,
  input  logic [RW-1:0] row,
  input  logic [1:0]    psel,
  output logic          done,
  output logic [PW-1:0] mult
);
  localparam int CIW = $clog2(NC);

  typedef enum logic [1:0] {M_IDLE, M_SCAN, M_REDUCE} mst_e;

  logic [CW-1:0] cand_tbl [NC];
  for (genvar gi = 0; gi < NC; gi++) begin : g_cand
    assign cand_tbl[gi] = CW'(cand_prime(gi));
  end

  mst_e           st_q, st_d;
  logic [CIW-1:0] ci_q, ci_d;
  logic [RW-1:0]  cnt_q, cnt_d;
  logic [RW-1:0]  tgt_q, tgt_d;
  logic [PW-1:0]  rem_q, rem_d;
  logic [PW-1:0]  m_q, m_d;
  logic           done_q, done_d;
  logic [PW-1:0]  pm1, q_ext;
  logic [RW-1:0]  tgt_now;

  assign pm1     = prime - PW'(1);
  assign q_ext   = PW'(cand_tbl[ci_q]);
  assign tgt_now = RW'(order_inverse(psel, 5'(row)));

  always_comb begin
    st_d   = st_q;
    ci_d   = ci_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    rem_d  = rem_q;
    m_d    = m_q;
    done_d = done_q;
    if (kick) begin
      done_d = 1'b0;
      tgt_d  = tgt_now;
      ci_d   = '0;
      cnt_d  = '0;
      rem_d  = pm1;
      if (tgt_now == '0) begin
        m_d  = PW'(1);
        st_d = M_REDUCE;
      end else begin
        st_d = M_SCAN;
      end
    end else begin
      case (st_q)
        M_SCAN: begin
          if (rem_q >= q_ext) begin
            rem_d = rem_q - q_ext;
          end else if ((rem_q != '0) && (cnt_q + RW'(1) == tgt_q)) begin
            m_d  = q_ext;
            st_d = M_REDUCE;
          end else begin
            if (rem_q != '0) cnt_d = cnt_q + RW'(1);
            ci_d  = ci_q + CIW'(1);
            rem_d = pm1;
          end
        end
        M_REDUCE: begin
          if (m_q >= pm1) begin
            m_d = m_q - pm1;
          end else begin
            st_d   = M_IDLE;
            done_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      ci_q   <= '0;
      cnt_q  <= '0;
      tgt_q  <= '0;
      rem_q  <= '0;
      m_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ci_q   <= ci_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      rem_q  <= rem_d;
      m_q    <= m_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign mult = m_q;
endmodule

// File: rtl/intra_emit.sv
module intra_emit #(
  parameter int PW = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [PW-1:0] prime,
  input  logic [1:0]    ccase,
  input  logic [PW-1:0] mult,
  input  logic          swap,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [PW-1:0] rd_data,
  output logic          out_valid,
  output logic [PW-1:0] out_idx,
  output logic          out_last
);
  logic          run_q, run_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] e_q, e_d;
  logic          v1_q, last1_q;
  logic [PW-1:0] pos1_q;
  logic          v2_q, last2_q;
  logic [PW-1:0] idx2_q;
  logic [PW-1:0] last_pos, val;
  logic [PW:0]   e_sum, pm1x, e_wrap;
  logic          at_last;

  always_comb begin
    case (ccase)
      2'd1:    last_pos = prime;
      2'd2:    last_pos = prime - PW'(2);
      default: last_pos = prime - PW'(1);
    endcase
  end

  assign at_last = (pos_q == last_pos);
  assign e_sum   = {1'b0, e_q} + {1'b0, mult};
  assign pm1x    = {1'b0, prime - PW'(1)};
  assign e_wrap  = (e_sum >= pm1x) ? (e_sum - pm1x) : e_sum;

  always_comb begin
    run_d = run_q;
    pos_d = pos_q;
    e_d   = e_q;
    if (go) begin
      run_d = 1'b1;
      pos_d = '0;
      e_d   = '0;
    end else if (run_q) begin
      if (at_last) begin
        run_d = 1'b0;
      end else begin
        pos_d = pos_q + PW'(1);
        e_d   = e_wrap[PW-1:0];
      end
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = e_q[AW-1:0];

  // End corrections applied to the RAM word read for position pos1_q.
  always_comb begin
    val = rd_data;
    if (swap && (pos1_q == '0))               val = prime;
    else if (swap && (pos1_q == prime))       val = PW'(1);
    else if (pos1_q == prime - PW'(1))        val = '0;
    else if (pos1_q == prime)                 val = prime;
    else if (ccase == 2'd2)                   val = rd_data - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      e_q     <= '0;
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      pos1_q  <= '0;
      v2_q    <= 1'b0;
      last2_q <= 1'b0;
      idx2_q  <= '0;
    end else begin
      run_q   <= run_d;
      pos_q   <= pos_d;
      e_q     <= e_d;
      v1_q    <= run_q;
      last1_q <= run_q && at_last;
      pos1_q  <= pos_q;
      v2_q    <= v1_q;
      last2_q <= last1_q;
      if (v1_q) idx2_q <= val;
    end
  end

  assign out_valid = v2_q;
  assign out_idx   = idx2_q;
  assign out_last  = last2_q;
endmodule

// File: rtl/intra_row_perm_gen.sv
module intra_row_perm_gen
  import intra_perm_pkg::*;
#(
  parameter int PRIME_W  = intra_perm_pkg::PRIME_W,
  parameter int ADDR_W   = 8,
  parameter int ROOT_W   = 5,
  parameter int ROW_W    = intra_perm_pkg::ROW_W,
  parameter int NUM_CAND = intra_perm_pkg::NUM_CAND,
  parameter int CAND_W   = intra_perm_pkg::CAND_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PRIME_W-1:0] prime_p,
  input  logic [1:0]         col_case,
  input  logic [ROW_W-1:0]   row_idx,
  input  logic [1:0]         pat_sel,
  input  logic               full_blk,
  output logic               busy,
  output logic               col_valid,
  output logic [PRIME_W-1:0] col_idx,
  output logic               col_last
);
  typedef enum logic [1:0] {T_IDLE, T_PREP, T_EMIT} tst_e;

  tst_e               st_q, st_d;
  logic               kick_q, kick_d;
  logic [PRIME_W-1:0] p_q;
  logic [1:0]         case_q, psel_q;
  logic [ROW_W-1:0]   row_q;
  logic               full_q;
  logic               accept, ready, swap;
  logic               base_done, mult_done;
  logic [PRIME_W-1:0] mult;
  logic               ram_we, ram_re;
  logic [ADDR_W-1:0]  ram_waddr, ram_raddr;
  logic [PRIME_W-1:0] ram_wdata, ram_rdata;

  assign accept = (st_q == T_IDLE) && start;
  assign ready  = (st_q == T_PREP) && !kick_q && base_done && mult_done;
  assign swap   = (case_q == CCASE_PLUS) && full_q &&
                  (5'(row_q) == last_row(psel_q));

  always_comb begin
    st_d   = st_q;
    kick_d = 1'b0;
    case (st_q)
      T_IDLE: if (start) begin
        st_d   = T_PREP;
        kick_d = 1'b1;
      end
      T_PREP: if (ready) st_d = T_EMIT;
      T_EMIT: if (col_last) st_d = T_IDLE;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      kick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kick_q <= kick_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= '0;
      case_q <= '0;
      psel_q <= '0;
      row_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      p_q    <= prime_p;
      case_q <= col_case;
      psel_q <= pat_sel;
      row_q  <= row_idx;
      full_q <= full_blk;
    end
  end

  intra_base_seq #(.PW(PRIME_W), .AW(ADDR_W), .GW(ROOT_W)) i_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick_q),
    .prime   (p_q),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .done    (base_done)
  );

  intra_mult_sel #(.PW(PRIME_W), .RW(ROW_W), .NC(NUM_CAND), .CW(CAND_W)) i_mult (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (kick_q),
    .prime (p_q),
    .row   (row_q),
    .psel  (psel_q),
    .done  (mult_done),
    .mult  (mult)
  );

  intra_seq_ram #(.DW(PRIME_W), .AW(ADDR_W)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  intra_emit #(.PW(PRIME_W), .AW(ADDR_W)) i_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (ready),
    .prime     (p_q),
    .ccase     (case_q),
    .mult      (mult),
    .swap      (swap),
    .rd_en     (ram_re),
    .rd_addr   (ram_raddr),
    .rd_data   (ram_rdata),
    .out_valid (col_valid),
    .out_idx   (col_idx),
    .out_last  (col_last)
  );

  assign busy = (st_q != T_IDLE);
endmodule

// File: rtl/intra_row_perm_chk.sv
module intra_row_perm_chk #(
  parameter int PRIME_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [PRIME_W-1:0] prime_p,
  input logic [1:0]         col_case,
  input logic               busy,
  input logic               col_valid,
  input logic [PRIME_W-1:0] col_idx,
  input logic               col_last
);
  logic [PRIME_W-1:0] p_lat;
  logic [1:0]         case_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_lat    <= '0;
      case_lat <= '0;
    end else if (start && !busy) begin
      p_lat    <= prime_p;
      case_lat <= col_case;
    end
  end

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> busy);

  p_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> col_valid);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |=> !busy);

  p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_idx <= p_lat));

  p_minus_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && case_lat == 2'd2) |-> (col_idx <= p_lat - PRIME_W'(2)));
endmodule

bind intra_row_perm_gen intra_row_perm_chk #(.PRIME_W(PRIME_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .prime_p   (prime_p),
  .col_case  (col_case),
  .busy      (busy),
  .col_valid (col_valid),
  .col_idx   (col_idx),
  .col_last  (col_last)
);

// File: tb/test_intra_row_perm_gen.sv
module test_intra_row_perm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLEN     = 300;
  localparam int ROW_LIMIT  = 20000;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [8:0] prime_p;
  logic [1:0] col_case;
  logic [4:0] row_idx;
  logic [1:0] pat_sel;
  logic       full_blk;
  logic       busy, col_valid, col_last;
  logic [8:0] col_idx;

  int n_checks = 0;
  int n_errs   = 0;
  int got   [MAXLEN];
  int exp_v [MAXLEN];
  int got_n, exp_n;

  int ord_a [20] = '{19,9,14,4,0,2,5,7,12,18,10,8,13,17,3,1,16,6,15,11};
  int ord_b [20] = '{19,9,14,4,0,2,5,7,12,18,16,13,17,15,3,1,6,11,8,10};
  int ord_c [10] = '{9,8,7,6,5,4,3,2,1,0};

  intra_row_perm_gen i_intra_row_perm_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .prime_p(prime_p),
    .col_case(col_case), .row_idx(row_idx), .pat_sel(pat_sel),
    .full_blk(full_blk), .busy(busy), .col_valid(col_valid),
    .col_idx(col_idx), .col_last(col_last));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit m_prime(int n);
    if (n < 2) return 0;
    for (int d = 2; d * d <= n; d++) if (n % d == 0) return 0;
    return 1;
  endfunction

  function automatic int m_root(int p);
    for (int g = 2; g < p; g++) begin
      int x = 1;
      bit ok = 1;
      for (int i = 1; i <= p - 2; i++) begin
        x = (x * g) % p;
        if (x == 1) begin ok = 0; break; end
      end
      if (ok) return g;
    end
    return 0;
  endfunction

  function automatic int m_mult(int p, int row, int sel);
    int k = 0;
    int cnt = 0;
    for (int j = 0; j < 20; j++) begin
      int e = (sel == 1) ? ord_b[j] : (sel == 2) ? ((j < 10) ? ord_c[j] : -1) : ord_a[j];
      if (e == row) k = j;
    end
    if (k == 0) return 1;
    for (int q = 7; q < 1000; q++) begin
      if (m_prime(q) && ((p - 1) % q != 0)) begin
        cnt++;
        if (cnt == k) return q;
      end
    end
    return 1;
  endfunction

  function automatic void build_expect(int p, int cc, int row, int sel, bit full);
    int g = m_root(p);
    int m = m_mult(p, row, sel);
    int c [MAXLEN];
    int lastrow = (sel == 2) ? 9 : 19;
    c[0] = 1;
    for (int i = 1; i <= p - 2; i++) c[i] = (c[i-1] * g) % p;
    exp_n = (cc == 1) ? p + 1 : (cc == 2) ? p - 1 : p;
    for (int pos = 0; pos < exp_n; pos++) begin
      if (pos <= p - 2) begin
        exp_v[pos] = c[(pos * m) % (p - 1)];
        if (cc == 2) exp_v[pos] = exp_v[pos] - 1;
      end else if (pos == p - 1) exp_v[pos] = 0;
      else exp_v[pos] = p;
    end
    if (cc == 1 && full && row == lastrow) begin
      exp_v[0] = p;
      exp_v[p] = 1;
    end
  endfunction

  // One row: start, scramble inputs, optionally poke start mid-run, collect and compare.
  task automatic run_row(int p, int cc, int row, int sel, bit full, string req, bit poke);
    int cyc = 0;
    int gaps = 0;
    int idle_cyc = 0;
    int bad_pos = -1;
    bit fin = 0;
    bit prev_v = 0;
    build_expect(p, cc, row, sel, full);
    @(posedge clk); #1;
    prime_p = 9'(p); col_case = 2'(cc); row_idx = 5'(row); pat_sel = 2'(sel);
    full_blk = full; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    prime_p = 9'd101; col_case = 2'(2 - cc); row_idx = 5'(19 - row); pat_sel = 2'(1 - (sel % 2));
    full_blk = ~full;
    got_n = 0;
    while (!fin && cyc < ROW_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) start = 1'b1;
      if (poke && cyc == 4) start = 1'b0;
      if (!busy) idle_cyc++;
      if (col_valid) begin
        if (got_n > 0 && !prev_v) gaps++;
        if (got_n < MAXLEN) got[got_n] = int'(col_idx);
        got_n++;
        if (col_last) fin = 1;
      end
      prev_v = col_valid;
    end
    start = 1'b0;
    check(fin, req, "row completed before row limit", cyc, ROW_LIMIT);
    check(got_n == exp_n, req, "index count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (bad_pos < 0 && got[i] != exp_v[i]) bad_pos = i;
    end
    if (bad_pos >= 0)
      check(0, req, $sformatf("index at position %0d", bad_pos), got[bad_pos], exp_v[bad_pos]);
    else
      check(1, req, "indices", 0, 0);
    check(gaps == 0, "R9", "gaps in valid stream", gaps, 0);
    check(idle_cyc == 0, "R9", "busy low while row in progress", idle_cyc, 0);
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after last index", int'(busy), 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(col_valid == 1'b0, "R1", "col_valid after reset", int'(col_valid), 0);
    check(col_last == 1'b0, "R1", "col_last after reset", int'(col_last), 0);
  endtask

  task automatic t_eq_small();
    run_row(17, 0, 4, 0, 0, "R4", 0);      // R3: position 3 multiplier
  endtask

  task automatic t_root_large();
    run_row(191, 0, 19, 0, 0, "R2", 0);    // multiplier 1 exposes the root 19
  endtask

  task automatic t_pattern_b();
    run_row(41, 0, 16, 1, 0, "R8", 0);     // R3 with pattern 1
  endtask

  task automatic t_plus();
    run_row(53, 1, 19, 0, 0, "R5", 0);     // last row but not full: no exchange
    run_row(53, 1, 3, 0, 1, "R6", 0);      // full but not last row: no exchange
  endtask

  task automatic t_plus_swap();
    run_row(53, 1, 19, 0, 1, "R6", 0);     // last row of a 20-row pattern
    run_row(53, 1, 9, 2, 1, "R6", 0);      // last row of the 10-row pattern (R8)
  endtask

  task automatic t_minus();
    run_row(257, 2, 10, 1, 0, "R7", 0);
  endtask

  task automatic t_busy_ignore();
    run_row(29, 0, 0, 0, 0, "R10", 1);
  endtask

  initial begin
    start = 0; prime_p = 0; col_case = 0; row_idx = 0; pat_sel = 0; full_blk = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_eq_small();
    t_root_large();
    t_pattern_b();
    t_plus();
    t_plus_swap();
    t_minus();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: got %0d cycles expected completion", 150000);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule